// File: doc/BRIEF.md
# Dual-Channel High/Low-Count Pulse Generator

This block generates two independent pulse trains meant to feed the RC filters of a pair of analog output stages. Each channel's waveform is set by two 16-bit counts: a high phase length and a low phase length, both in clock cycles. The output is high for the first count, low for the second, and the pattern repeats. The period is therefore the sum of the two counts, and the duty cycle is the high count divided by that sum.

Software drives the block through a small synchronous register port. A write strobe stores a 16-bit word at an even byte offset. A combinational read path returns the word at the addressed offset. One shared control word holds a run bit for each channel and one spare enable bit. The spare bit is stored and read back, but it has no effect inside this block.

A channel copies its two counts from the registers only when a new period begins. The host may rewrite the counts at any time without ever producing a shortened or stretched pulse. Clearing a channel's run bit forces its output low and resets its phase position. Setting the bit again starts a fresh period.

Top module: `twin_pwm`

## Requirements
- R1: The word at byte offset 2 holds channel 0's high count and offset 4 holds its low count. Offsets 6 and 8 hold the same pair for channel 1. Each of these reads back the last value written. Even offsets above 8 and all odd offsets read as zero, and writes to them change nothing.
- R2: Byte offset 0 is the control word. Bit 0 runs channel 0, bit 1 runs channel 1, and bit 2 is a stored spare enable. All three read back as written. Bits 15 to 3 always read zero, whatever is written to them.
- R3: A running channel with high count H > 0 and low count L > 0 is high for exactly H cycles, then low for L cycles, repeating. If the write that sets the run bit lands on clock edge E, the first high cycle begins at edge E+1.
- R4: When a channel's run bit is clear, its output is low from the next clock edge onward. After the bit is set again, the channel starts a new period from the beginning of the high phase.
- R5: Counts written while a channel runs take effect only at the first edge of the next period. The period in progress completes with the old counts.
- R6: A high count of zero gives a constant low output, including when the low count is also zero.
- R7: A low count of zero with a nonzero high count gives a constant high output.
- R8: The two channels run independently: different counts and run bits on one channel never alter the other's waveform.
- R9: While reset is asserted, all registers read zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset of the addressed register |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pwm_out | output | 2 | Pulse outputs, bit i for channel i |

## Verification
The bench targets the period boundary. A count rewrite lands in the middle of a period, and the expected trace checks that this period still ends with the old counts. A design that reloads the counts immediately would emit a clipped pulse there. The zero-count cases are checked for a constant level. A design that treats a zero count as a full counter wrap would instead produce long pulses or a one-cycle glitch. The bench also covers re-enabling after a stop, which must begin with a full high phase (a leftover phase position would shorten it), and writes to reserved bits, unmapped offsets and odd offsets. A loose decoder would either store those values or let them read back.

// File: rtl/twin_pwm_pkg.sv
package twin_pwm_pkg;

    // word index (byte offset / 2) of the control word
    localparam int CTRL_WORD = 0;

    // word index of the high-phase count of channel ch
    function automatic int hi_word(input int ch);
        return 1 + 2 * ch;
    endfunction

    // word index of the low-phase count of channel ch
    function automatic int lo_word(input int ch);
        return 2 + 2 * ch;
    endfunction

endpackage

// File: rtl/twin_pwm_regs.sv
module twin_pwm_regs
    import twin_pwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4,
    parameter int NCH    = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  logic [CNT_W-1:0]              bus_wdata,
    output logic [CNT_W-1:0]              bus_rdata,
    output logic [NCH-1:0]                chan_en,
    output logic [NCH-1:0][CNT_W-1:0]     hi_cnt,
    output logic [NCH-1:0][CNT_W-1:0]     lo_cnt
);

    localparam int CTRL_W = NCH + 1;
    localparam int WIDX_W = ADDR_W - 1;

    typedef struct packed {
        logic [CTRL_W-1:0]            ctrl;
        logic [NCH-1:0][CNT_W-1:0]    hi;
        logic [NCH-1:0][CNT_W-1:0]    lo;
    } regs_t;

    regs_t r_d, r_q;

    logic              aligned;
    logic [WIDX_W-1:0] widx;

    assign aligned = ~bus_addr[0];
    assign widx    = bus_addr[ADDR_W-1:1];

    always_comb begin
        r_d = r_q;
        if (bus_wr && aligned) begin
            if (int'(widx) == CTRL_WORD) begin
                r_d.ctrl = bus_wdata[CTRL_W-1:0];
            end
            for (int i = 0; i < NCH; i++) begin
                if (int'(widx) == hi_word(i)) r_d.hi[i] = bus_wdata;
                if (int'(widx) == lo_word(i)) r_d.lo[i] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (int'(widx) == CTRL_WORD) begin
                bus_rdata[CTRL_W-1:0] = r_q.ctrl;
            end
            for (int i = 0; i < NCH; i++) begin
                if (int'(widx) == hi_word(i)) bus_rdata = r_q.hi[i];
                if (int'(widx) == lo_word(i)) bus_rdata = r_q.lo[i];
            end
        end
    end

    assign chan_en = r_q.ctrl[NCH-1:0];
    assign hi_cnt  = r_q.hi;
    assign lo_cnt  = r_q.lo;

endmodule

// File: rtl/twin_pwm_chan.sv
module twin_pwm_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] hi_cfg,
    input  logic [CNT_W-1:0] lo_cfg,
    output logic             pwm_o,
    output logic             period_go
);

    localparam int POS_W = CNT_W + 1;

    typedef struct packed {
        logic             run;
        logic [POS_W-1:0] pos;
        logic [CNT_W-1:0] act_hi;
        logic [CNT_W-1:0] act_lo;
        logic             out;
    } chan_t;

    chan_t st_d, st_q;

    logic [POS_W-1:0] span;
    logic [POS_W-1:0] pos_nx;
    logic             last;

    assign span      = {1'b0, st_q.act_hi} + {1'b0, st_q.act_lo};
    assign pos_nx    = st_q.pos + 1'b1;
    assign last      = (pos_nx >= span);
    assign period_go = en && (!st_q.run || last);

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else if (period_go) begin
            st_d.run    = 1'b1;
            st_d.pos    = '0;
            st_d.act_hi = hi_cfg;
            st_d.act_lo = lo_cfg;
            st_d.out    = (hi_cfg != '0);
        end else begin
            st_d.pos = pos_nx;
            st_d.out = (pos_nx < {1'b0, st_q.act_hi});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = st_q.out;

endmodule

// File: rtl/twin_pwm.sv
module twin_pwm #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4,
    parameter int NCH    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    pwm_out
);

    logic [NCH-1:0]              chan_en;
    logic [NCH-1:0]              chan_go;
    logic [NCH-1:0][CNT_W-1:0]   hi_cnt;
    logic [NCH-1:0][CNT_W-1:0]   lo_cnt;

    twin_pwm_regs #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .NCH    (NCH)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .chan_en   (chan_en),
        .hi_cnt    (hi_cnt),
        .lo_cnt    (lo_cnt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        twin_pwm_chan #(
            .CNT_W (CNT_W)
        ) chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (chan_en[i]),
            .hi_cfg    (hi_cnt[i]),
            .lo_cfg    (lo_cnt[i]),
            .pwm_o     (pwm_out[i]),
            .period_go (chan_go[i])
        );
    end

endmodule

// File: rtl/twin_pwm_chk.sv
module twin_pwm_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4,
    parameter int NCH    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic [CNT_W-1:0]  bus_rdata,
    input logic [NCH-1:0]    pwm_out,
    input logic [NCH-1:0]    chan_en,
    input logic [NCH-1:0]    chan_go
);

    // R2: control bits above the spare enable never read back
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata[CNT_W-1:NCH+1] == '0))
        else $error("reserved control bits not zero");

    // R2: a control write lands in the run bits on the next cycle
    p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0) |=> (chan_en == $past(bus_wdata[NCH-1:0])))
        else $error("control write not stored");

    // R1: unmapped and odd offsets read zero
    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[0] || int'(bus_addr[ADDR_W-1:1]) > 2 * NCH) |-> (bus_rdata == '0))
        else $error("unmapped offset reads nonzero");

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // R4: a stopped channel drives low
        p_off_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_en[i] |=> !pwm_out[i])
            else $error("stopped channel output high");

        // R5: a rising output only ever follows a period start
        p_rise_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwm_out[i]) |-> $past(chan_go[i]))
            else $error("output rose inside a period");
    end

endmodule

bind twin_pwm twin_pwm_chk #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .NCH    (NCH)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .chan_en   (chan_en),
    .chan_go   (chan_go)
);

// File: tb/twin_pwm_tb_top.sv
module twin_pwm_tb_top;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 4;
    localparam int NCH    = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [CNT_W-1:0]  bus_wdata = '0;
    logic [CNT_W-1:0]  bus_rdata;
    logic [NCH-1:0]    pwm_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    typedef struct {
        logic [1:0] mask;
        logic [1:0] val;
        string      req;
    } exp_t;

    exp_t expq[$];

    always #10 clk = ~clk;   // 50 MHz

    twin_pwm #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NCH(NCH)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // monitor: one expected output item per cycle, sampled after the negative edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                if (e.mask != 2'b00) begin
                    n_checks++;
                    if ((pwm_out & e.mask) !== (e.val & e.mask)) begin
                        n_errors++;
                        $display("FAIL %s: pwm_out actual=%b expected=%b (mask %b)",
                                 e.req, pwm_out & e.mask, e.val & e.mask, e.mask);
                    end
                end
            end
        end
    end

    task automatic push(input logic [1:0] m, input logic [1:0] v, input string r);
        exp_t e;
        e.mask = m; e.val = v; e.req = r;
        expq.push_back(e);
    endtask

    // requirement model: high for hi cycles, low for lo cycles, repeat
    function automatic logic wave_bit(input int hi, input int lo, input int k);
        if (hi + lo == 0) return 1'b0;
        return ((k % (hi + lo)) < hi);
    endfunction

    task automatic push_wave(input int ch, input int hi, input int lo, input int n,
                             input string r);
        for (int k = 0; k < n; k++) begin
            logic [1:0] v;
            v = '0;
            v[ch] = wave_bit(hi, lo, k);
            push(2'b01 << ch, v, r);
        end
    endtask

    // called at a negative edge; returns at the next negative edge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_check(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] e,
                            input string r);
        bus_addr = a;
        #1;
        n_checks++;
        if (bus_rdata !== e) begin
            n_errors++;
            $display("FAIL %s: read @%0d actual=%h expected=%h", r, a, bus_rdata, e);
        end
    endtask

    task automatic drain;
        wait (expq.size() == 0);
        @(negedge clk);
    endtask

    task automatic stop_all(input string r);
        wr(4'd0, 16'h0000);
        push(2'b00, 2'b00, r);          // last cycle of the old setting
        push(2'b11, 2'b00, r);
        push(2'b11, 2'b00, r);
        drain();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        n_checks++;
        if (pwm_out !== 2'b00) begin
            n_errors++;
            $display("FAIL R9: pwm_out in reset actual=%b expected=00", pwm_out);
        end
        rd_check(4'd0, 16'h0000, "R9");
        rd_check(4'd2, 16'h0000, "R9");
        rd_check(4'd8, 16'h0000, "R9");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: count registers, unmapped and odd offsets
        wr(4'd2, 16'h1234);
        wr(4'd4, 16'hABCD);
        wr(4'd6, 16'h0F0F);
        wr(4'd8, 16'h8001);
        wr(4'd10, 16'hFFFF);
        wr(4'd3, 16'h5555);
        rd_check(4'd2, 16'h1234, "R1");
        rd_check(4'd4, 16'hABCD, "R1");
        rd_check(4'd6, 16'h0F0F, "R1");
        rd_check(4'd8, 16'h8001, "R1");
        rd_check(4'd10, 16'h0000, "R1");
        rd_check(4'd3, 16'h0000, "R1");
        rd_check(4'd14, 16'h0000, "R1");

        // R2: control word, reserved bits
        wr(4'd0, 16'hFFFF);
        rd_check(4'd0, 16'h0007, "R2");
        wr(4'd0, 16'h0004);
        rd_check(4'd0, 16'h0004, "R2");
        push(2'b00, 2'b00, "R2");
        push(2'b11, 2'b00, "R2");       // spare bit alone runs nothing
        drain();
        stop_all("R2");

        // R3: basic waveform on channel 0
        wr(4'd2, 16'd3);
        wr(4'd4, 16'd2);
        wr(4'd0, 16'h0001);
        push(2'b01, 2'b00, "R3");
        push_wave(0, 3, 2, 15, "R3");
        drain();

        // R4: stop forces low, restart begins a full high phase
        stop_all("R4");
        push_wave(0, 0, 1, 4, "R4");
        drain();
        wr(4'd0, 16'h0001);
        push(2'b01, 2'b00, "R4");
        push_wave(0, 3, 2, 10, "R4");
        drain();
        stop_all("R4");

        // R5: mid-period rewrite waits for the next period
        wr(4'd0, 16'h0001);
        push(2'b01, 2'b00, "R5");
        push_wave(0, 3, 2, 5, "R5");
        push_wave(0, 1, 1, 6, "R5");
        @(negedge clk);
        @(negedge clk);
        wr(4'd2, 16'd1);
        wr(4'd4, 16'd1);
        drain();
        stop_all("R5");

        // R6: zero high count is constant low
        wr(4'd2, 16'd0);
        wr(4'd4, 16'd3);
        wr(4'd0, 16'h0001);
        push(2'b01, 2'b00, "R6");
        push_wave(0, 0, 3, 10, "R6");
        drain();
        wr(4'd4, 16'd0);
        push_wave(0, 0, 0, 10, "R6");
        drain();
        stop_all("R6");

        // R7: zero low count is constant high
        wr(4'd2, 16'd4);
        wr(4'd4, 16'd0);
        wr(4'd0, 16'h0001);
        push(2'b01, 2'b00, "R7");
        push_wave(0, 4, 0, 12, "R7");
        drain();
        stop_all("R7");

        // R8: independent channels, then channel 1 alone
        wr(4'd2, 16'd2);
        wr(4'd4, 16'd1);
        wr(4'd6, 16'd1);
        wr(4'd8, 16'd3);
        wr(4'd0, 16'h0003);
        push(2'b11, 2'b00, "R8");
        for (int k = 0; k < 12; k++) begin
            push(2'b11, {wave_bit(1, 3, k), wave_bit(2, 1, k)}, "R8");
        end
        drain();
        stop_all("R8");
        wr(4'd0, 16'h0002);
        push(2'b11, 2'b00, "R8");
        for (int k = 0; k < 8; k++) begin
            push(2'b11, {wave_bit(1, 3, k), 1'b0}, "R8");
        end
        drain();
        stop_all("R8");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule